// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small serial nonvolatile memory of 64 words of 16 bits, held in flip-flops and reached over a three-wire link: a chip select, a shift clock and a serial data input, plus a serial data output that comes with its own output enable. All three pins are sampled by a system clock. Shift-clock edges are found after synchronization, so the link runs far slower than the system clock.

A host frames each command by raising chip select. It then shifts in a start bit of 1, a two-bit opcode and a six-bit address, most significant bit first. Reads return a leading zero and then the stored word. Writes, single-word erase, erase-all and write-all are guarded by a program-enable latch. That latch is cleared at reset and set or cleared by two extended commands. Every accepted programming command starts a busy period whose length is a parameter counted in system clocks. While that period runs, raising chip select shows busy (0) or ready (1) on the data line.

Top module: `wire3_nvm_slave`

## Requirements
- R1: After reset the output enable is low, programming is disabled and every word reads 16'hFFFF.
- R2: A frame opens after chip select is seen high. Shift-clock rises carrying 0 before the first 1 are skipped. That first 1 is followed by a 2-bit opcode and a 6-bit address, MSB first. Opcode encoding: 2'b10 read, 2'b01 write, 2'b11 erase, 2'b00 extended. For the extended opcode, address bits [5:4] choose the function: 2'b11 enable, 2'b00 disable, 2'b10 erase-all, 2'b01 write-all.
- R3: A read drives the output enable high and presents a 0 after the last address bit. It then presents data bits 15 down to 0, one per shift-clock rise. The rise after bit 0 releases the output. Reads work whether programming is enabled or disabled.
- R4: Write, erase, erase-all and write-all take effect only while programming is enabled. Otherwise they are discarded and no busy period starts.
- R5: An enable command keeps programming enabled until a disable command arrives.
- R6: A write stores the 16 bits that follow the address, MSB first, with no prior erase needed. Its busy period starts after the last data bit.
- R7: An erase sets the addressed word to 16'hFFFF. Its busy period starts once the header is decoded.
- R8: Erase-all sets every word to 16'hFFFF. Write-all loads every word with the 16 bits that follow the header.
- R9: A busy period lasts PROG_CYCLES system clocks. If chip select rises during it, the output enable goes high and data out reads 0 until the period ends, then 1 until chip select falls.
- R10: Shift-clock activity while chip select is held high during a busy period is ignored and changes no word.
- R11: Lowering chip select ends any frame and releases the output. A write cut off before its 16th data bit changes nothing and starts no busy period.
- R12: Every response to a pin change, whether a shift-clock rise or a chip-select edge, appears at the outputs on the third system-clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, acts as power-up |
| sel_i | input | 1 | Chip select, high frames a command |
| sclk_i | input | 1 | Serial shift clock |
| sdin_i | input | 1 | Serial data input, sampled on shift-clock rise |
| sdout_o | output | 1 | Serial data output: read data or ready/busy |
| sdout_oe_o | output | 1 | Output enable for sdout_o |

## Verification
Each pin change passes through two synchronizer flops, and one more register before it reaches the outputs. A new read bit, the leading zero, the status bit and the output release therefore all appear on the third system-clock edge after the pin moved. The bench drives its pins on falling system-clock edges and holds each level for three rising edges before it updates its expected outputs. It compares those expected outputs with the ports on every falling edge. The end of a busy period is predicted as PROG_CYCLES plus two clocks after the accepting shift-clock edge has taken effect, and the status comparison skips only the single cycle on either side of that point.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    // Opcode field, first two bits after the start bit
    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    // Extended functions, taken from the two top address bits
    localparam logic [1:0] SUB_LOCK = 2'b00;
    localparam logic [1:0] SUB_FILL = 2'b01;
    localparam logic [1:0] SUB_WIPE = 2'b10;
    localparam logic [1:0] SUB_OPEN = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_HDR,
        ST_READ,
        ST_WDATA,
        ST_STATUS,
        ST_HOLD
    } nvm_state_e;

endpackage

// File: rtl/nvm_pin_sync.sv
module nvm_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], pin_i};
    end

    assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            left_q <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            left_q <= CW'(CYCLES - 1);
        end else if (busy_o) begin
            if (left_q == '0) busy_o <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/nvm_word_array.sv
module nvm_word_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              all_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] rd_tab [WORDS];

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '1;
            else if (we_i && (all_i || waddr_i == ADDR_W'(gi)))
                word_q <= wdata_i;
        end
        assign rd_tab[gi] = word_q;
    end

    assign rdata_o = rd_tab[raddr_i];
endmodule

// File: rtl/wire3_nvm_slave.sv
module wire3_nvm_slave
    import nvm_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdin_i,
    output logic sdout_o,
    output logic sdout_oe_o
);
    localparam int HDR_W = 2 + ADDR_W;
    localparam int CMAX  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
    localparam int CNT_W = $clog2(CMAX + 1);

    // Pin synchronization and shift-clock edge
    logic [2:0] pin_lvl;
    logic       cs_lvl, sk_lvl, di_lvl, sk_prev_q, sk_rise;

    nvm_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({sel_i, sclk_i, sdin_i}),
        .lvl_o (pin_lvl)
    );

    assign cs_lvl  = pin_lvl[2];
    assign sk_lvl  = pin_lvl[1];
    assign di_lvl  = pin_lvl[0];
    assign sk_rise = sk_lvl & ~sk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_prev_q <= 1'b0;
        else        sk_prev_q <= sk_lvl;
    end

    // State and datapath registers
    nvm_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [HDR_W-2:0]  hdr_q;
    logic [DATA_W-2:0] wbuf_q;
    logic [DATA_W:0]   shreg_q;
    logic              wen_q;
    logic              go_q, go_all_q;
    logic [ADDR_W-1:0] go_addr_q;
    logic [DATA_W-1:0] go_data_q;
    logic              busy;
    logic              rd_act;
    logic [DATA_W-1:0] rd_word;

    // Header and data decode
    logic [HDR_W-1:0]  hdr_next;
    logic [1:0]        opc, sub;
    logic [ADDR_W-1:0] adr;
    logic [DATA_W-1:0] wdata_next;
    logic              hdr_done, wd_done, takes_data, is_wipe;

    assign hdr_next   = {hdr_q, di_lvl};
    assign opc        = hdr_next[HDR_W-1 -: 2];
    assign adr        = hdr_next[ADDR_W-1:0];
    assign sub        = adr[ADDR_W-1 -: 2];
    assign wdata_next = {wbuf_q, di_lvl};
    assign hdr_done   = (state_q == ST_HDR) && sk_rise && (cnt_q == CNT_W'(HDR_W - 1));
    assign wd_done    = (state_q == ST_WDATA) && sk_rise && (cnt_q == CNT_W'(DATA_W - 1));
    assign takes_data = (opc == OP_WRITE) || (opc == OP_EXT && sub == SUB_FILL);
    assign is_wipe    = (opc == OP_ERASE) || (opc == OP_EXT && sub == SUB_WIPE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_lvl) state_d = busy ? ST_STATUS : ST_START;
            ST_START:  if (sk_rise && di_lvl) state_d = ST_HDR;
            ST_HDR: begin
                if (hdr_done) begin
                    if (opc == OP_READ)            state_d = ST_READ;
                    else if (takes_data && wen_q)  state_d = ST_WDATA;
                    else                           state_d = ST_HOLD;
                end
            end
            ST_READ:   if (sk_rise && cnt_q == CNT_W'(DATA_W)) state_d = ST_HOLD;
            ST_WDATA:  if (wd_done) state_d = ST_HOLD;
            ST_STATUS: state_d = ST_STATUS;
            ST_HOLD:   state_d = ST_HOLD;
            default:   state_d = ST_IDLE;
        endcase
        if (!cs_lvl) state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            hdr_q     <= '0;
            wbuf_q    <= '0;
            shreg_q   <= '0;
            wen_q     <= 1'b0;
            go_q      <= 1'b0;
            go_all_q  <= 1'b0;
            go_addr_q <= '0;
            go_data_q <= '0;
        end else begin
            go_q <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_START: begin
                    cnt_q <= '0;
                    hdr_q <= '0;
                end
                ST_HDR: begin
                    if (sk_rise) begin
                        hdr_q <= hdr_next[HDR_W-2:0];
                        cnt_q <= cnt_q + 1'b1;
                        if (hdr_done) begin
                            cnt_q     <= '0;
                            go_addr_q <= adr;
                            go_all_q  <= (opc == OP_EXT);
                            shreg_q   <= {1'b0, rd_word};
                            if (is_wipe) begin
                                go_q      <= wen_q;
                                go_data_q <= '1;
                            end
                            if (opc == OP_EXT && sub == SUB_OPEN) wen_q <= 1'b1;
                            if (opc == OP_EXT && sub == SUB_LOCK) wen_q <= 1'b0;
                        end
                    end
                end
                ST_READ: begin
                    if (sk_rise) begin
                        shreg_q <= {shreg_q[DATA_W-1:0], 1'b0};
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                ST_WDATA: begin
                    if (sk_rise) begin
                        wbuf_q <= wdata_next[DATA_W-2:0];
                        cnt_q  <= cnt_q + 1'b1;
                        if (wd_done) begin
                            go_q      <= 1'b1;
                            go_data_q <= wdata_next;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (go_q),
        .busy_o  (busy)
    );

    nvm_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (go_q),
        .all_i   (go_all_q),
        .waddr_i (go_addr_q),
        .wdata_i (go_data_q),
        .raddr_i (adr),
        .rdata_o (rd_word)
    );

    assign rd_act     = (state_q == ST_READ);
    assign sdout_oe_o = rd_act || (state_q == ST_STATUS);
    assign sdout_o    = (state_q == ST_STATUS) ? ~busy : shreg_q[DATA_W];
endmodule

// File: rtl/nvm_slave_chk.sv
module nvm_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_i,
    input logic oe,
    input logic dout,
    input logic go,
    input logic wen,
    input logic busy,
    input logic rd_act
);
    // Chip select low for three clocks releases the output
    assert_oe_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && $past(!sel_i) && $past(!sel_i, 2) && $past(!sel_i, 3)) |-> !oe);

    // A programming strobe needs the enable latch set
    assert_prog_guarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> wen);

    // No programming strobe while a busy period runs
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

    // Every accepted strobe opens a busy period on the next clock
    assert_busy_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    // Read output begins with the dummy zero
    assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_act) |-> !dout);
endmodule

bind wire3_nvm_slave nvm_slave_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel_i),
    .oe     (sdout_oe_o),
    .dout   (sdout_o),
    .go     (go_q),
    .wen    (wen_q),
    .busy   (busy),
    .rd_act (rd_act)
);

// File: tb/test_wire3_nvm_slave.sv
`timescale 1ns/1ps
module test_wire3_nvm_slave;
    localparam int PROG = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0;
    logic sdout, sdout_oe;

    always #2.5 clk = ~clk;

    wire3_nvm_slave #(.PROG_CYCLES(PROG)) i_wire3_nvm_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel),
        .sclk_i     (sclk),
        .sdin_i     (sdin),
        .sdout_o    (sdout),
        .sdout_oe_o (sdout_oe)
    );

    // Behavioural reference state
    logic [15:0] m [64];
    bit    wen_m = 0;
    int    cyc = 0, ready_at = 0;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    logic  exp_oe = 0, exp_dout = 0, nxt_oe = 0, nxt_dout = 0;
    bit    stat_mode = 0, nxt_go = 0;
    string cur_req = "R1";
    logic  ed;
    bit    skip;

    function automatic bit busy_m();
        return cyc < ready_at + 2;
    endfunction

    // Compare outputs against the model on every clock
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && !done) begin
            ed   = stat_mode ? (cyc >= ready_at) : exp_dout;
            skip = stat_mode && (cyc >= ready_at - 1) && (cyc <= ready_at + 1);
            n_cmp++;
            if (sdout_oe !== exp_oe) begin
                n_bad++;
                $display("FAIL %s/R12: oe=%b expected %b at cycle %0d", cur_req, sdout_oe, exp_oe, cyc);
            end else if (exp_oe && !skip && sdout !== ed) begin
                n_bad++;
                $display("FAIL %s/R12: dout=%b expected %b at cycle %0d", cur_req, sdout, ed, cyc);
            end
        end
    end

    task automatic clk_bit(input logic b);
        sclk = 1'b1; sdin = b;
        repeat (3) @(posedge clk);
        exp_oe = nxt_oe; exp_dout = nxt_dout;
        if (nxt_go) begin ready_at = cyc + PROG + 2; nxt_go = 0; end
        @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cs_set(input logic v);
        bit bz;
        bz = busy_m();
        sel = v;
        repeat (3) @(posedge clk);
        if (v && bz) begin exp_oe = 1; stat_mode = 1; end
        else         begin exp_oe = 0; stat_mode = 0; end
        nxt_oe = exp_oe;
        @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] op, input logic [5:0] adr,
                         input logic [15:0] wd, input int npre, input int ndata);
        logic [8:0] h;
        h = {1'b1, op, adr};
        cs_set(1);
        nxt_oe = 0; nxt_dout = 0;
        for (int i = 0; i < npre; i++) clk_bit(1'b0);
        for (int i = 8; i >= 0; i--) begin
            if (i == 0) begin
                if (op == 2'b10) begin nxt_oe = 1; nxt_dout = 0; end
                if (wen_m && (op == 2'b11 || (op == 2'b00 && adr[5:4] == 2'b10))) nxt_go = 1;
            end
            clk_bit(h[i]);
        end
        if (op == 2'b11 && wen_m) m[adr] = 16'hFFFF;
        if (op == 2'b00 && adr[5:4] == 2'b10 && wen_m)
            for (int k = 0; k < 64; k++) m[k] = 16'hFFFF;
        if (op == 2'b00 && adr[5:4] == 2'b11) wen_m = 1;
        if (op == 2'b00 && adr[5:4] == 2'b00) wen_m = 0;
        if (op == 2'b10) begin
            for (int i = 15; i >= 0; i--) begin nxt_dout = m[adr][i]; clk_bit(1'b0); end
            nxt_oe = 0;
            clk_bit(1'b0);
        end
        if (op == 2'b01 || (op == 2'b00 && adr[5:4] == 2'b01)) begin
            for (int i = 15; i >= 16 - ndata; i--) begin
                if (i == 0 && wen_m) nxt_go = 1;
                clk_bit(wd[i]);
            end
            if (ndata == 16 && wen_m) begin
                if (op == 2'b01) m[adr] = wd;
                else for (int k = 0; k < 64; k++) m[k] = wd;
            end
        end
        cs_set(0);
    endtask

    task automatic rd(input logic [5:0] a, input string req);
        cur_req = req;
        frame(2'b10, a, 16'h0, 0, 16);
    endtask

    task automatic probe(input int n, input string req);
        cur_req = req;
        cs_set(1);
        repeat (n) @(negedge clk);
        cs_set(0);
    endtask

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL all: watchdog expired, actual running expected finished");
        summary();
    end

    initial begin
        for (int k = 0; k < 64; k++) m[k] = 16'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: released output and erased contents after reset
        n_cmp++;
        if (sdout_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: oe=%b expected 0", sdout_oe);
        end
        repeat (4) @(negedge clk);
        rd(6'd7, "R1");
        // R4: write while disabled is discarded, no status shown
        cur_req = "R4";
        frame(2'b01, 6'd3, 16'h1234, 0, 16);
        probe(10, "R4");
        rd(6'd3, "R4");
        // R5, R2: enable, then write with status polling (R6, R9)
        cur_req = "R5"; frame(2'b00, 6'b110000, 16'h0, 0, 16);
        cur_req = "R6"; frame(2'b01, 6'd3, 16'hA5C3, 0, 16);
        probe(PROG + 10, "R9");
        rd(6'd3, "R6");
        cur_req = "R2"; frame(2'b10, 6'd3, 16'h0, 3, 16);
        cur_req = "R6"; frame(2'b01, 6'd63, 16'h0F0F, 0, 16);
        probe(PROG + 10, "R9");
        rd(6'd63, "R2");
        // R7: erase, busy right after the header
        cur_req = "R7"; frame(2'b11, 6'd3, 16'h0, 0, 16);
        probe(PROG + 10, "R7");
        rd(6'd3, "R7");
        // R10: commands clocked during a busy period are ignored
        cur_req = "R10"; frame(2'b01, 6'd10, 16'h5555, 0, 16);
        cs_set(1);
        nxt_oe = 1;
        for (int i = 8; i >= 0; i--) clk_bit(i == 8 || i == 7 || i == 6 || i <= 5);
        repeat (PROG) @(negedge clk);
        cs_set(0);
        rd(6'd63, "R10");
        rd(6'd10, "R10");
        // R11: write cut short by chip select
        cur_req = "R11"; frame(2'b01, 6'd20, 16'h00FF, 0, 8);
        probe(10, "R11");
        rd(6'd20, "R11");
        // R8: write-all then erase-all
        cur_req = "R8"; frame(2'b00, 6'b010000, 16'h1357, 0, 16);
        probe(PROG + 10, "R8");
        rd(6'd0, "R8"); rd(6'd20, "R8"); rd(6'd63, "R8");
        cur_req = "R8"; frame(2'b00, 6'b100000, 16'h0, 0, 16);
        probe(PROG + 10, "R8");
        rd(6'd9, "R8");
        cur_req = "R6"; frame(2'b01, 6'd4, 16'h8001, 0, 16);
        probe(PROG + 10, "R6");
        // R5: disable protects again; R3: read while disabled
        cur_req = "R5"; frame(2'b00, 6'b000000, 16'h0, 0, 16);
        cur_req = "R5"; frame(2'b01, 6'd4, 16'h0000, 0, 16);
        probe(10, "R5");
        rd(6'd4, "R3");
        repeat (5) @(negedge clk);
        summary();
    end
endmodule